// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Filler-Driven Receive

This block moves one byte at a time over a four-wire serial link, either as the clock-driving master or as a slave that follows an external clock and select. Software reaches it through a small register bus: a control byte, a clock divider, a status byte and a data port. Writing the data port loads the shift register and, in master mode, starts eight SCK pulses. Reading the data port returns the byte most recently shifted in.

When a byte completes, a ready flag is set. The service field of the control byte routes that flag to nothing (polled), to an interrupt line or to a DMA request line. Any access to the data port clears it. For receive-only traffic in master mode, a filler option is available. With it, a read of the data port on an idle link launches the next transfer by itself and shifts out all-ones, so software never writes a dummy byte.

Clock polarity and phase are selectable. Bits travel MSB first. The master SCK half-period is the divider value plus one clock cycle.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control, divider and status registers all read 0x00, `irq` and `dma_req` are low, `spi_sck_oe` is low, and `spi_sdo_oe` is low while `spi_ss_n` is high.
- R2: The bus map uses four addresses: 0 is control, 1 is divider, 2 is status (bit 0 ready, bit 1 busy) and 3 is data. The control byte reads back as written. Its fields are: bits [6:5] service mode (00 polled, 01 interrupt, 10 DMA, 11 treated as polled), bit 4 SCK output enable, bit 3 master (1) or slave (0), bit 2 clock polarity, bit 1 clock phase, and bit 0 filler mode.
- R3: In master mode a transfer produces exactly 16 SCK transitions. Consecutive transitions are spaced divider+1 clock cycles apart. Between transfers SCK rests at the polarity bit (0 gives idle low, 1 gives idle high).
- R4: Data travels MSB first and full duplex. With phase 0, the input is sampled on the first (leading) edge of each SCK pulse and the output changes on the trailing edge. With phase 1, the output changes on the leading edge and the input is sampled on the trailing edge. After 8 bits the data port returns the received byte.
- R5: Ready (status bit 0) rises after the eighth bit completes. A write or a read of the data port clears it.
- R6: `irq` equals ready when the service mode is 01, and `dma_req` equals ready when the mode is 10. With mode 00 or 11 both stay low.
- R7: `spi_sck_oe` is high only when master and SCK-enable are both set. `spi_sdo_oe` is high in master mode, and in slave mode while `spi_ss_n` is low.
- R8: In master mode with filler mode set, a data-port read on an idle link starts a transfer that sends 0xFF. With filler mode clear, such a read starts nothing.
- R9: In slave mode the block shifts on external `spi_sck_i` edges while `spi_ss_n` is low. Taking `spi_ss_n` high mid-byte discards the partial bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sck_o | output | 1 | Master serial clock |
| spi_sck_oe | output | 1 | Serial clock output enable |
| spi_sck_i | input | 1 | Serial clock from an external master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Serial data output enable |
| spi_sdi | input | 1 | Serial data in |
| irq | output | 1 | Byte-complete interrupt request |
| dma_req | output | 1 | Byte-complete DMA request |

## Verification
A wrong edge counter shows up as an SCK pulse count other than eight, or as ready rising early or late. Either becomes visible within one byte time, at most 16×(divider+1) cycles. A phase or polarity slip rotates the received or transmitted byte by one bit, so the model's captured byte and the data-port byte differ at the end of that same transfer. A stale ready or service decode shows on `irq` or `dma_req` in the cycle after the byte completes or after the data-port access that should have cleared it.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef enum logic [1:0] {
    SVC_POLL = 2'b00,
    SVC_IRQ  = 2'b01,
    SVC_DMA  = 2'b10,
    SVC_RSV  = 2'b11
  } svc_mode_e;

  typedef struct packed {
    logic      spare;
    svc_mode_e svc;
    logic      sck_en;
    logic      master;
    logic      cpol;
    logic      cpha;
    logic      filler;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;
endpackage

// File: rtl/spi_ctl_tick.sv
module spi_ctl_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  always_comb begin
    hit   = (cnt_q >= limit);
    tick  = run && hit;
    cnt_d = (!run || hit) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         master,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         tick,
  input  logic         sck_i,
  input  logic         ss_n,
  input  logic         sdi,
  output logic         busy,
  output logic         done,
  output logic         sck_lvl,
  output logic         sdo,
  output logic [W-1:0] rx
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic [2:0]    sck_s_q;
  logic [1:0]    ss_s_q, sdi_s_q;
  logic [W-1:0]  sh_q, sh_d;
  logic [EW-1:0] cnt_q, cnt_d;
  logic cap_q, cap_d, obit_q, obit_d, lvl_q, lvl_d, busy_q, busy_d;
  logic ev, lead, samp, shft, din, last, s_abort;

  always_comb begin
    s_abort = !master && ss_s_q[1];
    ev      = master ? (busy_q && tick)
                     : (!ss_s_q[1] && (sck_s_q[2] != sck_s_q[1]));
    lead    = master ? !cnt_q[0] : (sck_s_q[1] != cpol);
    samp    = ev && (lead != cpha);
    shft    = ev && (lead == cpha);
    din     = master ? sdi : sdi_s_q[1];
    last    = ev && (cnt_q == EW'(EDGES - 1));

    sh_d   = sh_q;
    cnt_d  = cnt_q;
    cap_d  = cap_q;
    obit_d = obit_q;
    lvl_d  = lvl_q;
    busy_d = busy_q;
    if (start) begin
      sh_d   = load;
      obit_d = load[W-1];
      cnt_d  = '0;
      lvl_d  = 1'b0;
      busy_d = master;
    end else if (s_abort) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (ev) begin
      cnt_d  = last ? '0 : cnt_q + 1'b1;
      busy_d = !last;
      if (master) lvl_d = !lvl_q;
      if (samp) begin
        if (cpha) sh_d[0] = din;
        else      cap_d   = din;
      end
      if (shft) begin
        if (cpha) begin
          obit_d = sh_q[W-1];
          sh_d   = {sh_q[W-2:0], 1'b0};
        end else begin
          sh_d   = {sh_q[W-2:0], cap_q};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s_q <= '0;
      ss_s_q  <= '1;
      sdi_s_q <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      cap_q   <= 1'b0;
      obit_q  <= 1'b0;
      lvl_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      sck_s_q <= {sck_s_q[1:0], sck_i};
      ss_s_q  <= {ss_s_q[0], ss_n};
      sdi_s_q <= {sdi_s_q[0], sdi};
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      obit_q  <= obit_d;
      lvl_q   <= lvl_d;
      busy_q  <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign done    = last;
  assign sck_lvl = lvl_q;
  assign sdo     = cpha ? obit_q : sh_q[W-1];
  assign rx      = sh_q;

  // R3: an idle master holds SCK at its resting level
  p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy_q) |-> !lvl_q);
  // R3: SCK moves only on a divider tick
  p_sck_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && busy_q && !tick) |=> $stable(lvl_q));
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck_o,
  output logic              spi_sck_oe,
  input  logic              spi_sck_i,
  input  logic              spi_ss_n,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic              spi_sdi,
  output logic              irq,
  output logic              dma_req
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [1:0]        rs_q;
  logic              srst_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] div_q, div_d;
  logic              ready_q, ready_d;
  logic              wr_data, rd_data, filler_go, eng_start;
  logic [DATA_W-1:0] eng_load, eng_rx;
  logic              eng_busy, eng_done, eng_lvl, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  always_comb begin
    wr_data   = bus_wr && (bus_addr == ADDR_DATA);
    rd_data   = bus_rd && (bus_addr == ADDR_DATA);
    filler_go = rd_data && ctrl_q.filler && ctrl_q.master && !eng_busy;
    eng_start = !eng_busy && (wr_data || filler_go);
    eng_load  = filler_go ? '1 : bus_wdata;

    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (bus_wr && bus_addr == ADDR_CTRL) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    if (bus_wr && bus_addr == ADDR_DIV)  div_d  = bus_wdata;

    ready_d = ready_q;
    if (eng_done)                ready_d = 1'b1;
    else if (wr_data || rd_data) ready_d = 1'b0;

    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
      ADDR_DIV:  bus_rdata = div_q;
      ADDR_STAT: bus_rdata = DATA_W'({eng_busy, ready_q});
      default:   bus_rdata = eng_rx;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
      ready_q <= ready_d;
    end
  end

  spi_ctl_tick #(.CW(DATA_W)) u_tick (
    .clk(clk), .rst_n(srst_n), .run(eng_busy && ctrl_q.master),
    .limit(div_q), .tick(tick)
  );

  spi_ctl_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst_n(srst_n), .master(ctrl_q.master), .cpol(ctrl_q.cpol),
    .cpha(ctrl_q.cpha), .start(eng_start), .load(eng_load), .tick(tick),
    .sck_i(spi_sck_i), .ss_n(spi_ss_n), .sdi(spi_sdi),
    .busy(eng_busy), .done(eng_done), .sck_lvl(eng_lvl), .sdo(spi_sdo), .rx(eng_rx)
  );

  assign spi_sck_o  = ctrl_q.cpol ^ eng_lvl;
  assign spi_sck_oe = ctrl_q.master && ctrl_q.sck_en;
  assign spi_sdo_oe = ctrl_q.master || !spi_ss_n;
  assign irq        = ready_q && (ctrl_q.svc == SVC_IRQ);
  assign dma_req    = ready_q && (ctrl_q.svc == SVC_DMA);

  // R5: ready rises only at the end of an active byte
  p_ready_src_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(ready_q) |-> $past(eng_busy));
  // R5: a started transfer leaves ready clear
  p_start_clr_r5: assert property (@(posedge clk) disable iff (!srst_n)
    eng_start |=> !ready_q);
  // R8: a filler read launches the engine
  p_filler_go_r8: assert property (@(posedge clk) disable iff (!srst_n)
    filler_go |=> eng_busy);
  // R6: interrupt and DMA requests never coincide
  p_svc_excl_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !(irq && dma_req));
endmodule

// File: tb/spi_ctl_tb.sv
module spi_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_sck_o, spi_sck_oe, spi_sdo, spi_sdo_oe, irq, dma_req;
  logic       sck_in = 1'b0, ss_n = 1'b1, s_sdi = 1'b0, tb_slave = 1'b0;
  logic       spi_sdi;

  logic       m_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_bo = 1'b0, m_prev = 1'b0, m_bad = 1'b0;
  logic [7:0] m_tx = 8'h00, m_rx = 8'h00, m_div = 8'h00;
  int         m_edges = 0, m_last = 0, cyc = 0;
  int         checks = 0, fails = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  assign spi_sdi = tb_slave ? s_sdi : (m_cpha ? m_bo : m_tx[7]);

  spi_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck_o(spi_sck_o),
    .spi_sck_oe(spi_sck_oe), .spi_sck_i(sck_in), .spi_ss_n(ss_n), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .spi_sdi(spi_sdi), .irq(irq), .dma_req(dma_req)
  );

  // bench model of the remote slave, evaluated away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!m_en) m_prev <= spi_sck_o;
    else if (spi_sck_o != m_prev) begin
      m_prev <= spi_sck_o;
      if (m_edges > 0 && (cyc - m_last) != int'(m_div) + 1) m_bad <= 1'b1;
      m_last  <= cyc;
      m_edges <= m_edges + 1;
      if ((spi_sck_o != m_cpol) != m_cpha) m_rx <= {m_rx[6:0], spi_sdo};
      else begin
        if (m_cpha) m_bo <= m_tx[7];
        m_tx <= {m_tx[6:0], 1'b0};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_ready(output logic ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      peek(2'd2, s);
      ok = s[0];
    end
  endtask

  task automatic arm_model(input logic [7:0] ctrl, input logic [7:0] dv, input logic [7:0] sv);
    m_en = 1'b0;
    @(negedge clk);
    m_cpol = ctrl[2]; m_cpha = ctrl[1]; m_div = dv;
    m_tx = sv; m_bo = 1'b0; m_rx = 8'h00; m_edges = 0; m_bad = 1'b0;
    wr(2'd0, ctrl);
    wr(2'd1, dv);
    @(negedge clk); m_en = 1'b1;
  endtask

  task automatic slave_bit(input logic b);
    s_sdi = b; repeat (8) @(negedge clk);
    sck_in = 1'b1; repeat (8) @(negedge clk);
    sck_in = 1'b0; repeat (8) @(negedge clk);
  endtask

  // ctrl, divider, byte written, byte the model returns
  localparam logic [31:0] VEC [6] = '{
    {8'h18, 8'd1, 8'hA5, 8'h3C},
    {8'h3C, 8'd2, 8'h81, 8'h7E},
    {8'h5A, 8'd0, 8'h0F, 8'hF0},
    {8'h1E, 8'd3, 8'hC3, 8'h96},
    {8'h78, 8'd1, 8'h5A, 8'h01},
    {8'h3A, 8'd4, 8'hE7, 8'h18}
  };

  initial begin
    logic [7:0] d;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(2'd0, d); chk("R1 ctrl", d, 8'h00);
    peek(2'd1, d); chk("R1 div", d, 8'h00);
    peek(2'd2, d); chk("R1 status", d, 8'h00);
    chk("R1 irq/dma", {irq, dma_req}, 2'b00);
    chk("R1 oe", {spi_sck_oe, spi_sdo_oe}, 2'b00);

    // R2 control readback
    wr(2'd0, 8'h6B); peek(2'd0, d); chk("R2 ctrl readback", d, 8'h6B);
    // R7 master without SCK enable
    wr(2'd0, 8'h08); @(negedge clk);
    chk("R7 sck_oe off", spi_sck_oe, 1'b0);
    chk("R7 sdo_oe master", spi_sdo_oe, 1'b1);

    foreach (VEC[i]) begin
      logic [7:0] c, dv, tx, sv;
      {c, dv, tx, sv} = VEC[i];
      arm_model(c, dv, sv);
      chk("R7 sck_oe on", spi_sck_oe, 1'b1);
      chk("R3 idle level before", spi_sck_o, c[2]);
      wr(2'd3, tx);
      wait_ready(ok);
      chk("R5 ready set", ok, 1'b1);
      chk("R3 edge count", m_edges, 16);
      chk("R3 half period", m_bad, 1'b0);
      chk("R3 idle level after", spi_sck_o, c[2]);
      chk("R4 remote got byte", m_rx, tx);
      chk("R6 irq", irq, c[6:5] == 2'b01);
      chk("R6 dma_req", dma_req, c[6:5] == 2'b10);
      rd(2'd3, d);
      chk("R4 received byte", d, sv);
      peek(2'd2, d);
      chk("R5 ready cleared by read", d[0], 1'b0);
      chk("R6 request dropped", {irq, dma_req}, 2'b00);
    end

    // R8 normal mode: reading the data port starts nothing
    arm_model(8'h18, 8'd1, 8'h00);
    rd(2'd3, d);
    repeat (40) @(negedge clk);
    chk("R8 no start without filler", m_edges, 0);
    peek(2'd2, d); chk("R8 idle status", d, 8'h00);

    // R8 filler mode: a read launches a 0xFF transfer
    arm_model(8'h39, 8'd1, 8'h55);
    rd(2'd3, d);
    wait_ready(ok);
    chk("R8 filler transfer done", ok, 1'b1);
    chk("R8 filler byte sent", m_rx, 8'hFF);
    chk("R6 irq in filler run", irq, 1'b1);
    m_en = 1'b0; @(negedge clk); m_tx = 8'hAA; m_rx = 8'h00; m_edges = 0; m_bad = 1'b0;
    @(negedge clk); m_en = 1'b1;
    rd(2'd3, d);
    chk("R8 first byte returned", d, 8'h55);
    peek(2'd2, d);
    chk("R5 ready cleared, next running", d[1:0], 2'b10);
    wait_ready(ok);
    rd(2'd3, d);
    chk("R8 second filler byte", d, 8'hAA);
    chk("R8 second 0xFF sent", m_rx, 8'hFF);
    wait_ready(ok);
    rd(2'd2, d);
    m_en = 1'b0;
    repeat (4) @(negedge clk);

    // R5 clear by data write: a finished byte followed by a new write
    arm_model(8'h18, 8'd0, 8'h00);
    wr(2'd3, 8'h12);
    wait_ready(ok);
    wr(2'd3, 8'h34);
    peek(2'd2, d);
    chk("R5 ready cleared by write", d[0], 1'b0);
    wait_ready(ok);
    rd(2'd3, d);
    m_en = 1'b0;

    // R9 slave transfer, polarity 0 phase 0
    tb_slave = 1'b1;
    wr(2'd0, 8'h00);
    chk("R7 sdo_oe slave deselected", spi_sdo_oe, 1'b0);
    wr(2'd3, 8'hB4);
    ss_n = 1'b0; repeat (8) @(negedge clk);
    chk("R7 sdo_oe slave selected", spi_sdo_oe, 1'b1);
    for (int b = 7; b >= 0; b--) begin
      s_sdi = 1'b0;
      chk("R9 slave sdo bit", spi_sdo, 8'hB4 >> b & 8'h01);
      slave_bit(8'h6D >> b & 8'h01);
    end
    ss_n = 1'b1; repeat (8) @(negedge clk);
    peek(2'd2, d); chk("R9 slave ready", d[0], 1'b1);
    rd(2'd3, d); chk("R9 slave byte", d, 8'h6D);

    // R9 deselect mid-byte discards partial count
    wr(2'd3, 8'h00);
    ss_n = 1'b0; repeat (8) @(negedge clk);
    for (int b = 0; b < 3; b++) slave_bit(1'b1);
    ss_n = 1'b1; repeat (8) @(negedge clk);
    peek(2'd2, d); chk("R9 no ready after abort", d[0], 1'b0);
    ss_n = 1'b0; repeat (8) @(negedge clk);
    for (int b = 7; b >= 0; b--) slave_bit(8'hC9 >> b & 8'h01);
    ss_n = 1'b1; repeat (8) @(negedge clk);
    peek(2'd2, d); chk("R9 ready after full byte", d[0], 1'b1);
    rd(2'd3, d); chk("R9 byte after abort", d, 8'hC9);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule